// File: doc/BRIEF.md
# System control register block

This block is the small bank of system control registers that sits beside a microcontroller core on a simple word-wide read/write bus. A selected write updates the addressed register on the clock edge. Read data is a combinational function of the address and the current state, so it is valid in the same cycle as the select.

The bank returns a fixed identification word. It holds three low-power control bits and a two-bit urgency for each of three system handlers. It keeps the pending state of a timer exception, a software-pended service exception and a non-maskable interrupt. Each of these is set and cleared through separate write-one bits, and hardware request and entry strobes also act on it. From the pending state and the urgencies, the block reports the number of the exception that should be taken next. A reset request leaves the block as a one-cycle pulse, and only when the write carries the 16-bit unlock key.

All offsets are byte offsets of 32-bit words.

Top module: `sysctl_regs`

## Requirements
- R1: A read of offset 0x0 returns 0x000CC200: revision 0 in [3:0], part 0xC20 in [15:4], architecture 0xC in [19:16], and zero above. Writes to 0x0 do not change it.
- R2: Offset 0x10 holds three read-write bits: sleep-on-exit in bit 1, deep-sleep in bit 2 and event-on-pending in bit 4. Each drives its output, and every other bit of that word reads 0.
- R3: Offset 0x1C holds the supervisor-call urgency in [31:30]. Offset 0x20 holds the service urgency in [23:22] and the timer urgency in [31:30]. Every other bit reads 0, and each field drives its output.
- R4: At offset 0x4, writing 1 to bit 26 sets the timer pending flag and writing 1 to bit 25 clears it. Writing 0 to either bit has no effect. Bit 26 reads the flag and bit 25 reads 0. Setting and clearing in the same write leaves the flag clear.
- R5: At offset 0x4, writing 1 to bit 28 sets the service pending flag and writing 1 to bit 27 clears it. Bit 28 reads the flag and bit 27 reads 0. Setting and clearing in the same write leaves the flag clear.
- R6: The NMI pending flag is set by writing 1 to bit 31 of 0x4 or by `nmi_req`, and cleared by `nmi_taken`. When `nmi_req` arrives in the same cycle as `nmi_taken`, the flag stays set. Bit 31 reads the flag.
- R7: `tick_req` sets the timer pending flag, and it wins over a software clear (bit 25) in the same cycle.
- R8: Offset 0x4 shows `active_num` in [5:0], the pending vector in [17:12] and `ext_pend` in bit 22. Writes to these fields have no effect.
- R9: `pend_vec` shows the next exception number. NMI (2) always wins. Among supervisor call (11), service (14), timer (15) and the external interrupt (`ext_num`, urgency `ext_pri`), the lowest urgency value wins, and a tie goes to the lower number. The value is 0 when nothing is pending.
- R10: A write to 0xC with bit 2 set and bits [31:16] equal to 0x05FA raises `reset_req` for exactly the one cycle after that write. Any other write to 0xC does nothing, and 0xC reads 0.
- R11: Reads of unmapped offsets return 0, and writes to them change no state.
- R12: After reset, every writable bit, every pending flag and `reset_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transfer select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| active_num | input | VEC_W | Exception number currently active (0 = thread) |
| ext_pend | input | 1 | External interrupt pending |
| ext_num | input | VEC_W | External interrupt number |
| ext_pri | input | PRI_W | External interrupt urgency |
| svc_pend | input | 1 | Supervisor-call pending from core |
| nmi_req | input | 1 | Hardware NMI request |
| nmi_taken | input | 1 | Core entering NMI handler |
| tick_req | input | 1 | Timer exception request |
| sleep_on_exit | output | 1 | Sleep-on-exit control |
| deep_sleep | output | 1 | Deep-sleep select |
| evt_on_pend | output | 1 | Event-on-pending control |
| pri_svc | output | PRI_W | Supervisor-call urgency |
| pri_svcpend | output | PRI_W | Service exception urgency |
| pri_tick | output | PRI_W | Timer urgency |
| tick_pending | output | 1 | Timer pending flag |
| svcpend_pending | output | 1 | Service pending flag |
| nmi_pending | output | 1 | NMI pending flag |
| pend_vec | output | VEC_W | Next exception number |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with its defaults: 6-bit offsets, 6-bit exception numbers, 2-bit urgencies and key 0x05FA. The 6-bit offset space holds ten unmapped word slots beside the mapped ones, so stray writes and reads can be tried. The 2-bit urgency makes urgency ties easy to set up. An external number of 20 exercises the tie rule against the fixed handler numbers, and a one-bit change to the key shows that the key check covers the whole field.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W = 32;

  // byte offsets of the mapped words
  localparam int unsigned OFS_IDENT = 'h00;
  localparam int unsigned OFS_STAT  = 'h04;
  localparam int unsigned OFS_RSTC  = 'h0C;
  localparam int unsigned OFS_CTRL  = 'h10;
  localparam int unsigned OFS_URGA  = 'h1C;
  localparam int unsigned OFS_URGB  = 'h20;

  // status word bit positions
  localparam int unsigned B_TICK_CLR = 25;
  localparam int unsigned B_TICK_SET = 26;
  localparam int unsigned B_SVP_CLR  = 27;
  localparam int unsigned B_SVP_SET  = 28;
  localparam int unsigned B_NMI_SET  = 31;
  localparam int unsigned B_EXT      = 22;
  localparam int unsigned B_VEC_LO   = 12;

  // control word bit positions
  localparam int unsigned B_SOE  = 1;
  localparam int unsigned B_DEEP = 2;
  localparam int unsigned B_EVP  = 4;

  // reset control
  localparam int unsigned B_RST_REQ = 2;

  // fixed handler numbers
  localparam int unsigned NUM_NMI  = 2;
  localparam int unsigned NUM_SVC  = 11;
  localparam int unsigned NUM_SVP  = 14;
  localparam int unsigned NUM_TICK = 15;

  // pending flag index
  typedef enum logic [1:0] {PF_TICK = 2'd0, PF_SVP = 2'd1, PF_NMI = 2'd2} pend_idx_e;

  function automatic logic [WORD_W-1:0] ident_word();
    return {8'h00, 4'h0, 4'hC, 12'hC20, 4'h0};
  endfunction

  function automatic logic key_hit(input logic [WORD_W-1:0] w, input logic [15:0] key);
    return w[31:16] == key;
  endfunction
endpackage

// File: rtl/sysctl_pendbit.sv
module sysctl_pendbit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_sw,
  input  logic clr_sw,
  input  logic set_hw,
  input  logic clr_hw,
  output logic q
);
  // hardware set > any clear > software set
  always_ff @(posedge clk) begin
    if (!rst_n)             q <= 1'b0;
    else if (set_hw)        q <= 1'b1;
    else if (clr_sw|clr_hw) q <= 1'b0;
    else if (set_sw)        q <= 1'b1;
  end
endmodule

// File: rtl/sysctl_vecsel.sv
module sysctl_vecsel #(
  parameter int unsigned N     = 5,
  parameter int unsigned VEC_W = 6,
  parameter int unsigned PRI_W = 2
) (
  input  logic [N-1:0]                valid,
  input  logic [N-1:0][PRI_W:0]       urg,
  input  logic [N-1:0][VEC_W-1:0]     num,
  output logic [VEC_W-1:0]            win
);
  function automatic logic beats(input logic [PRI_W:0] ua, input logic [VEC_W-1:0] na,
                                 input logic [PRI_W:0] ub, input logic [VEC_W-1:0] nb);
    return (ua < ub) || ((ua == ub) && (na < nb));
  endfunction

  logic               found;
  logic [PRI_W:0]     best_u;
  logic [VEC_W-1:0]   best_n;

  always_comb begin
    found  = 1'b0;
    best_u = '0;
    best_n = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (valid[i] && (!found || beats(urg[i], num[i], best_u, best_n))) begin
        found  = 1'b1;
        best_u = urg[i];
        best_n = num[i];
      end
    end
    win = best_n;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned VEC_W   = 6,
  parameter int unsigned PRI_W   = 2,
  parameter logic [15:0] RST_KEY = 16'h05FA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [VEC_W-1:0]    active_num,
  input  logic                ext_pend,
  input  logic [VEC_W-1:0]    ext_num,
  input  logic [PRI_W-1:0]    ext_pri,
  input  logic                svc_pend,
  input  logic                nmi_req,
  input  logic                nmi_taken,
  input  logic                tick_req,
  output logic                sleep_on_exit,
  output logic                deep_sleep,
  output logic                evt_on_pend,
  output logic [PRI_W-1:0]    pri_svc,
  output logic [PRI_W-1:0]    pri_svcpend,
  output logic [PRI_W-1:0]    pri_tick,
  output logic                tick_pending,
  output logic                svcpend_pending,
  output logic                nmi_pending,
  output logic [VEC_W-1:0]    pend_vec,
  output logic                reset_req
);
  localparam int unsigned NPEND = 3;
  localparam int unsigned NCAND = 5;

  // decode strobes, named for the checker
  logic wr_cyc, wr_ctrl, wr_urga, wr_urgb, wr_stat, wr_rstc, key_ok;
  assign wr_cyc  = bus_sel && bus_wr;
  assign wr_ctrl = wr_cyc && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_urga = wr_cyc && (bus_addr == ADDR_W'(OFS_URGA));
  assign wr_urgb = wr_cyc && (bus_addr == ADDR_W'(OFS_URGB));
  assign wr_stat = wr_cyc && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_rstc = wr_cyc && (bus_addr == ADDR_W'(OFS_RSTC));
  assign key_ok  = key_hit(bus_wdata, RST_KEY);

  // control bits and urgencies
  logic             soe_q, deep_q, evp_q;
  logic [PRI_W-1:0] u_svc_q, u_svp_q, u_tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soe_q <= 1'b0; deep_q <= 1'b0; evp_q <= 1'b0;
      u_svc_q <= '0; u_svp_q <= '0; u_tick_q <= '0;
    end else begin
      if (wr_ctrl) begin
        soe_q  <= bus_wdata[B_SOE];
        deep_q <= bus_wdata[B_DEEP];
        evp_q  <= bus_wdata[B_EVP];
      end
      if (wr_urga) u_svc_q <= bus_wdata[31 -: PRI_W];
      if (wr_urgb) begin
        u_svp_q  <= bus_wdata[23 -: PRI_W];
        u_tick_q <= bus_wdata[31 -: PRI_W];
      end
    end
  end

  // pending flags
  logic [NPEND-1:0] p_set_sw, p_clr_sw, p_set_hw, p_clr_hw, p_q;
  assign p_set_sw[PF_TICK] = wr_stat && bus_wdata[B_TICK_SET];
  assign p_clr_sw[PF_TICK] = wr_stat && bus_wdata[B_TICK_CLR];
  assign p_set_hw[PF_TICK] = tick_req;
  assign p_clr_hw[PF_TICK] = 1'b0;
  assign p_set_sw[PF_SVP]  = wr_stat && bus_wdata[B_SVP_SET];
  assign p_clr_sw[PF_SVP]  = wr_stat && bus_wdata[B_SVP_CLR];
  assign p_set_hw[PF_SVP]  = 1'b0;
  assign p_clr_hw[PF_SVP]  = 1'b0;
  assign p_set_sw[PF_NMI]  = wr_stat && bus_wdata[B_NMI_SET];
  assign p_clr_sw[PF_NMI]  = 1'b0;
  assign p_set_hw[PF_NMI]  = nmi_req;
  assign p_clr_hw[PF_NMI]  = nmi_taken;

  for (genvar g = 0; g < int'(NPEND); g++) begin : g_pend
    sysctl_pendbit u_bit (
      .clk(clk), .rst_n(rst_n),
      .set_sw(p_set_sw[g]), .clr_sw(p_clr_sw[g]),
      .set_hw(p_set_hw[g]), .clr_hw(p_clr_hw[g]),
      .q(p_q[g])
    );
  end

  // next-exception selection; NMI gets an urgency above every 2-bit value
  logic [NCAND-1:0]              c_valid;
  logic [NCAND-1:0][PRI_W:0]     c_urg;
  logic [NCAND-1:0][VEC_W-1:0]   c_num;

  assign c_valid = {ext_pend, p_q[PF_TICK], p_q[PF_SVP], svc_pend, p_q[PF_NMI]};
  assign c_urg   = {{1'b1, ext_pri}, {1'b1, u_tick_q}, {1'b1, u_svp_q},
                    {1'b1, u_svc_q}, {(PRI_W+1){1'b0}}};
  assign c_num   = {ext_num, VEC_W'(NUM_TICK), VEC_W'(NUM_SVP),
                    VEC_W'(NUM_SVC), VEC_W'(NUM_NMI)};

  sysctl_vecsel #(.N(NCAND), .VEC_W(VEC_W), .PRI_W(PRI_W)) u_vecsel (
    .valid(c_valid), .urg(c_urg), .num(c_num), .win(pend_vec)
  );

  // reset request pulse
  logic rst_fire;
  assign rst_fire = wr_rstc && key_ok && bus_wdata[B_RST_REQ];

  always_ff @(posedge clk) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= rst_fire;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        ADDR_W'(OFS_IDENT): bus_rdata = ident_word();
        ADDR_W'(OFS_STAT): begin
          bus_rdata[VEC_W-1:0]               = active_num;
          bus_rdata[B_VEC_LO +: VEC_W]       = pend_vec;
          bus_rdata[B_EXT]                   = ext_pend;
          bus_rdata[B_TICK_SET]              = p_q[PF_TICK];
          bus_rdata[B_SVP_SET]               = p_q[PF_SVP];
          bus_rdata[B_NMI_SET]               = p_q[PF_NMI];
        end
        ADDR_W'(OFS_CTRL): begin
          bus_rdata[B_SOE]  = soe_q;
          bus_rdata[B_DEEP] = deep_q;
          bus_rdata[B_EVP]  = evp_q;
        end
        ADDR_W'(OFS_URGA): bus_rdata[31 -: PRI_W] = u_svc_q;
        ADDR_W'(OFS_URGB): begin
          bus_rdata[23 -: PRI_W] = u_svp_q;
          bus_rdata[31 -: PRI_W] = u_tick_q;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign sleep_on_exit   = soe_q;
  assign deep_sleep      = deep_q;
  assign evt_on_pend     = evp_q;
  assign pri_svc         = u_svc_q;
  assign pri_svcpend     = u_svp_q;
  assign pri_tick        = u_tick_q;
  assign tick_pending    = p_q[PF_TICK];
  assign svcpend_pending = p_q[PF_SVP];
  assign nmi_pending     = p_q[PF_NMI];
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int unsigned VEC_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      bus_wdata,
  input logic             wr_stat,
  input logic             wr_rstc,
  input logic             key_ok,
  input logic             svc_pend,
  input logic             ext_pend,
  input logic             nmi_req,
  input logic             nmi_taken,
  input logic             tick_req,
  input logic             tick_pending,
  input logic             svcpend_pending,
  input logic             nmi_pending,
  input logic [VEC_W-1:0] pend_vec,
  input logic             reset_req
);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  p_key_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_rstc && key_ok && bus_wdata[2]));

  p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pending |-> (pend_vec == VEC_W'(2)));

  p_idle_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_pending || tick_pending || svcpend_pending || svc_pend || ext_pend)
      |-> (pend_vec == '0));

  p_tick_hw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_req |=> tick_pending);

  p_nmi_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_taken && !nmi_req) |=> !nmi_pending);

  p_nmi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> nmi_pending);

  p_svp_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[28] && !bus_wdata[27]) |=> svcpend_pending);

  p_svp_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[27]) |=> !svcpend_pending);
endmodule

bind sysctl_regs sysctl_regs_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
  .wr_stat(wr_stat), .wr_rstc(wr_rstc), .key_ok(key_ok),
  .svc_pend(svc_pend), .ext_pend(ext_pend),
  .nmi_req(nmi_req), .nmi_taken(nmi_taken), .tick_req(tick_req),
  .tick_pending(tick_pending), .svcpend_pending(svcpend_pending),
  .nmi_pending(nmi_pending), .pend_vec(pend_vec), .reset_req(reset_req)
);

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned VEC_W  = 6;
  localparam int unsigned PRI_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [VEC_W-1:0] active_num = '0, ext_num = '0;
  logic ext_pend = 1'b0, svc_pend = 1'b0;
  logic [PRI_W-1:0] ext_pri = '0;
  logic nmi_req = 1'b0, nmi_taken = 1'b0, tick_req = 1'b0;
  logic sleep_on_exit, deep_sleep, evt_on_pend;
  logic [PRI_W-1:0] pri_svc, pri_svcpend, pri_tick;
  logic tick_pending, svcpend_pending, nmi_pending, reset_req;
  logic [VEC_W-1:0] pend_vec;

  always #2.5 clk = ~clk;

  sysctl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .active_num(active_num), .ext_pend(ext_pend), .ext_num(ext_num),
    .ext_pri(ext_pri), .svc_pend(svc_pend), .nmi_req(nmi_req),
    .nmi_taken(nmi_taken), .tick_req(tick_req),
    .sleep_on_exit(sleep_on_exit), .deep_sleep(deep_sleep),
    .evt_on_pend(evt_on_pend), .pri_svc(pri_svc), .pri_svcpend(pri_svcpend),
    .pri_tick(pri_tick), .tick_pending(tick_pending),
    .svcpend_pending(svcpend_pending), .nmi_pending(nmi_pending),
    .pend_vec(pend_vec), .reset_req(reset_req)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } rd_item_t;
  rd_item_t sb[$];

  function automatic logic [31:0] stat_w(input logic [5:0] act, input logic [5:0] vec,
                                         input logic ext, input logic tick,
                                         input logic svp, input logic nmi);
    logic [31:0] w = 32'h0;
    w[5:0]   = act;
    w[17:12] = vec;
    w[22]    = ext;
    w[26]    = tick;
    w[28]    = svp;
    w[31]    = nmi;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one write transfer, returns at the negedge after capture
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  // driver: one read, expected value goes to the scoreboard
  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    sb.push_back('{exp, tag});
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      if (sb.size() == 0) begin
        checks++; failures++;
        $display("FAIL monitor: read with empty scoreboard actual=%h expected=none", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: run hung actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 outputs", {sleep_on_exit, deep_sleep, evt_on_pend, pri_svc, pri_svcpend,
        pri_tick, tick_pending, svcpend_pending, nmi_pending, reset_req}, '0);
    chk("R12 pend_vec", 32'(pend_vec), 32'h0);
    rd(6'h04, 32'h0, "R12 status");
    rd(6'h10, 32'h0, "R12 control");
    rd(6'h20, 32'h0, "R12 urgency B");

    // R1 identification
    rd(6'h00, 32'h000CC200, "R1 ident");
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, 32'h000CC200, "R1 ident after write");

    // R2 control
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0000_0016, "R2 control all ones");
    chk("R2 outputs", {29'h0, sleep_on_exit, deep_sleep, evt_on_pend}, 32'h7);
    wr(6'h10, 32'h0000_0004);
    chk("R2 deep only", {29'h0, sleep_on_exit, deep_sleep, evt_on_pend}, 32'h2);
    wr(6'h10, 32'h0);
    rd(6'h10, 32'h0, "R2 control cleared");

    // R3 urgencies
    wr(6'h1C, 32'hFFFF_FFFF);
    rd(6'h1C, 32'hC000_0000, "R3 urgency A");
    wr(6'h20, 32'hFFFF_FFFF);
    rd(6'h20, 32'hC0C0_0000, "R3 urgency B");
    chk("R3 outputs", {26'h0, pri_svc, pri_svcpend, pri_tick}, 32'h3F);
    wr(6'h20, 32'h4000_0000);
    chk("R3 timer field only", {28'h0, pri_svcpend, pri_tick}, 32'h1);
    wr(6'h20, 32'hC0C0_0000);

    // R4 timer pending
    wr(6'h04, 32'h0400_0000);
    chk("R4 set", 32'(tick_pending), 32'h1);
    rd(6'h04, stat_w(0, 15, 0, 1, 0, 0), "R4 status after set");
    wr(6'h04, 32'h0);
    chk("R4 zero write no effect", 32'(tick_pending), 32'h1);
    wr(6'h04, 32'h0200_0000);
    chk("R4 clear", 32'(tick_pending), 32'h0);
    wr(6'h04, 32'h0400_0000);
    wr(6'h04, 32'h0600_0000);
    chk("R4 set+clear leaves clear", 32'(tick_pending), 32'h0);
    rd(6'h04, 32'h0, "R4 clear bit reads 0");

    // R5 service pending
    wr(6'h04, 32'h1000_0000);
    chk("R5 set", 32'(svcpend_pending), 32'h1);
    rd(6'h04, stat_w(0, 14, 0, 0, 1, 0), "R5 status");
    wr(6'h04, 32'h0800_0000);
    chk("R5 clear", 32'(svcpend_pending), 32'h0);
    wr(6'h04, 32'h1000_0000);
    wr(6'h04, 32'h1800_0000);
    chk("R5 set+clear leaves clear", 32'(svcpend_pending), 32'h0);

    // R6 NMI pending
    wr(6'h04, 32'h8000_0000);
    chk("R6 sw set", 32'(nmi_pending), 32'h1);
    rd(6'h04, stat_w(0, 2, 0, 0, 0, 1), "R6 status");
    @(negedge clk); nmi_taken = 1'b1;
    @(negedge clk); nmi_taken = 1'b0;
    chk("R6 taken clears", 32'(nmi_pending), 32'h0);
    @(negedge clk); nmi_req = 1'b1;
    @(negedge clk); nmi_req = 1'b0;
    chk("R6 hw request sets", 32'(nmi_pending), 32'h1);
    @(negedge clk); nmi_req = 1'b1; nmi_taken = 1'b1;
    @(negedge clk); nmi_req = 1'b0; nmi_taken = 1'b0;
    chk("R6 request during entry stays", 32'(nmi_pending), 32'h1);
    @(negedge clk); nmi_taken = 1'b1;
    @(negedge clk); nmi_taken = 1'b0;

    // R7 timer hardware request beats software clear
    @(negedge clk);
    tick_req = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h0200_0000;
    @(negedge clk);
    tick_req = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    chk("R7 request wins over clear", 32'(tick_pending), 32'h1);
    wr(6'h04, 32'h0200_0000);
    chk("R7 later clear", 32'(tick_pending), 32'h0);

    // R8 read-only status fields
    active_num = 6'd5; ext_pend = 1'b1; ext_num = 6'd20; ext_pri = 2'd3;
    rd(6'h04, stat_w(5, 20, 1, 0, 0, 0), "R8 status fields");
    wr(6'h04, 32'h0047_F03F);
    rd(6'h04, stat_w(5, 20, 1, 0, 0, 0), "R8 write to read-only fields");
    ext_pend = 1'b0; active_num = '0;

    // R9 next-exception selection
    wr(6'h1C, 32'h8000_0000);                 // svc urgency 2
    wr(6'h20, 32'h4040_0000);                 // service 1, timer 1
    wr(6'h04, 32'h1400_0000);                 // service + timer pending
    chk("R9 tie goes to lower number", 32'(pend_vec), 32'd14);
    svc_pend = 1'b1;
    @(negedge clk);
    chk("R9 less urgent svc loses", 32'(pend_vec), 32'd14);
    wr(6'h20, 32'h0040_0000);                 // timer urgency 0
    chk("R9 most urgent wins", 32'(pend_vec), 32'd15);
    ext_pend = 1'b1; ext_num = 6'd20; ext_pri = 2'd0;
    @(negedge clk);
    chk("R9 external tie loses", 32'(pend_vec), 32'd15);
    wr(6'h1C, 32'h0);                         // svc urgency 0
    chk("R9 svc tie wins by number", 32'(pend_vec), 32'd11);
    wr(6'h04, 32'h8000_0000);
    chk("R9 NMI always wins", 32'(pend_vec), 32'd2);
    @(negedge clk); nmi_taken = 1'b1;
    @(negedge clk); nmi_taken = 1'b0;
    wr(6'h04, 32'h0A00_0000);
    svc_pend = 1'b0; ext_pend = 1'b0;
    @(negedge clk);
    chk("R9 nothing pending", 32'(pend_vec), 32'd0);

    // R10 keyed reset request
    wr(6'h0C, 32'h05FA_0004);
    chk("R10 pulse high", 32'(reset_req), 32'h1);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(reset_req), 32'h0);
    wr(6'h0C, 32'h05FB_0004);
    chk("R10 wrong key", 32'(reset_req), 32'h0);
    wr(6'h0C, 32'h05FA_0000);
    chk("R10 request bit clear", 32'(reset_req), 32'h0);
    rd(6'h0C, 32'h0, "R10 reads zero");

    // R11 unmapped offsets
    wr(6'h10, 32'h0000_0016);
    wr(6'h14, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h10, 32'h0000_0016, "R11 control untouched");
    rd(6'h20, 32'h0040_0000, "R11 urgency B untouched");
    rd(6'h24, 32'h0, "R11 unmapped read");
    rd(6'h08, 32'h0, "R11 unmapped read 0x08");
    chk("R11 flags untouched", {29'h0, tick_pending, svcpend_pending, nmi_pending}, 32'h0);

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: reads left actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule